// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

This block is a binary up-counter with four channel registers. Each channel works either as a compare register, which gives a one-cycle match pulse when the count reaches its value, or as a capture register, which stores the count on a rising edge of its trigger input. An 8-bit option register on a simple write/read port holds one capture/compare select bit per channel and an overflow flag. The flag follows its own set and clear rules.

Firmware programs the channel values and select bits while counting is stopped, then raises the count enable. The mode input decides whether the select bits take effect and whether a wrap of the counter is reported. Mode encoding on `mode_i`: 0 is free-running, 1 is pulse-width measurement, and 2 and 3 are other modes.

Option register layout: bits [7:4] hold the select bits for channels 3..0 (bit 4+c belongs to channel c, 1 means capture and 0 means compare). Bits [3:1] are reserved. Bit 0 is the overflow flag.

Top module: `cc_timer`

## Requirements
- R1: After reset the option register reads 0x00, the count is 0, all channel values are 0, and no match or interrupt pulse is active.
- R2: While `en_i` is 1 the count rises by one every clock and wraps from all-ones to 0. A clock with `en_i` at 0 forces the count to 0.
- R3: When the count wraps in mode 0 or 1, bit 0 is set and `ovf_irq_o` pulses for exactly the cycle in which bit 0 first reads 1. A wrap in mode 2 or 3 sets nothing and gives no pulse.
- R4: Reading has no side effect. Once set, bit 0 stays at 1 until one of the clear conditions of R5 or R6 occurs.
- R5: A write with bit 0 at 0 clears the flag. A write with bit 0 at 1 never sets it. When a wrap in mode 0 or 1 and a clearing write fall on the same clock, the flag ends up set.
- R6: Any clock with `en_i` at 0 clears the flag.
- R7: Bits [7:4] take the written value when `en_i` is 0. While `en_i` is 1, a write updates them only if it carries their current value; any other value leaves them unchanged. The bit 0 rule still applies to that write.
- R8: Select bits act only in mode 0. In modes 1 to 3 every channel behaves as a compare channel.
- R9: Bits [3:1] of the option register always read 0.
- R10: A capture channel copies the count into its value on a clock where `en_i` is 1 and its trigger is 1 after being 0 on the previous clock. The new value is visible one clock later. A capture takes priority over a channel write on the same clock.
- R11: A compare channel with `en_i` at 1 and count equal to its value raises its `match_o` bit for one cycle, starting on the next clock. Channel values are loaded through `ch_we_i`/`ch_idx_i`/`ch_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| mode_i | input | 2 | Timer mode (0 free-run, 1 pulse width, 2/3 other) |
| trig_i | input | 4 | Per-channel capture triggers |
| opt_we_i | input | 1 | Option register write strobe |
| opt_wdata_i | input | 8 | Option register write data |
| opt_rdata_o | output | 8 | Option register read data |
| ch_we_i | input | 1 | Channel value write strobe |
| ch_idx_i | input | 2 | Channel selected for writing |
| ch_wdata_i | input | CNT_W | Channel write data |
| cnt_o | output | CNT_W | Current count |
| ch_val_o | output | 4*CNT_W | Channel values, channel c at bits [c*CNT_W +: CNT_W] |
| match_o | output | 4 | Compare match pulses |
| ovf_irq_o | output | 1 | Overflow interrupt pulse |

## Verification
Every result is registered, so a stimulus applied before clock edge k shows up right after edge k. This covers the count step, a captured value, the match pulse, the flag, the interrupt and a select write. The bench changes inputs on the falling edge and compares all outputs on the next falling edge against a behavioural model that is updated on the rising edge. Each result is therefore checked exactly one edge after its cause. A clearing write is placed on the wrap clock itself to exercise the priority rule. The bench uses an 8-bit counter so that many wraps fit in a short run.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int N_CH  = 4;
  localparam int OPT_W = 8;
  localparam int IDX_W = $clog2(N_CH);

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_PWM   = 2'd1,
    MODE_OTH_A = 2'd2,
    MODE_OTH_B = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i && (cnt_q == CNT_MAX);

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_stop_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/cc_opt_reg.sv
module cc_opt_reg
  import cc_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ovf_hit_i,
  input  logic             we_i,
  input  logic [OPT_W-1:0] wdata_i,
  output logic [N_CH-1:0]  sel_o,
  output logic             ovf_o,
  output logic             irq_o,
  output logic [OPT_W-1:0] rdata_o
);
  logic [N_CH-1:0] sel_q;
  logic            ovf_q, irq_q;
  logic            sel_wr_ok;

  // while counting, only a same-value write reaches the select field
  assign sel_wr_ok = we_i && (!en_i || (wdata_i[7:4] == sel_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (sel_wr_ok) sel_q <= wdata_i[7:4];
      if (!en_i)                     ovf_q <= 1'b0;
      else if (ovf_hit_i)            ovf_q <= 1'b1;
      else if (we_i && !wdata_i[0])  ovf_q <= 1'b0;
      irq_q <= ovf_hit_i;
    end
  end

  assign sel_o   = sel_q;
  assign ovf_o   = ovf_q;
  assign irq_o   = irq_q;
  assign rdata_o = {sel_q, 3'b000, ovf_q};

  p_irq_with_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ovf_q);
  p_no_sw_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_q && !ovf_hit_i) |=> !ovf_q);
  p_en_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ovf_q);
  p_sel_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i && (wdata_i[7:4] != sel_q)) |=> $stable(sel_q));
  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[3:1] == 3'b000);
endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cap_en_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] val_o,
  output logic             match_o
);
  logic [CNT_W-1:0] val_q;
  logic             trig_q, match_q;
  logic             cap_now;

  assign cap_now = en_i && cap_en_i && trig_i && !trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= '0;
      trig_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (cap_now)   val_q <= cnt_i;
      else if (we_i) val_q <= wdata_i;
      match_q <= en_i && !cap_en_i && (cnt_i == val_q);
    end
  end

  assign val_o   = val_q;
  assign match_o = match_q;

  p_cap_no_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i |=> !match_q);
  p_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_now |=> (val_q == $past(cnt_i)));
  p_idle_no_match_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !match_q);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [1:0]            mode_i,
  input  logic [N_CH-1:0]       trig_i,
  input  logic                  opt_we_i,
  input  logic [OPT_W-1:0]      opt_wdata_i,
  output logic [OPT_W-1:0]      opt_rdata_o,
  input  logic                  ch_we_i,
  input  logic [IDX_W-1:0]      ch_idx_i,
  input  logic [CNT_W-1:0]      ch_wdata_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [N_CH*CNT_W-1:0] ch_val_o,
  output logic [N_CH-1:0]       match_o,
  output logic                  ovf_irq_o
);
  tmr_mode_e        mode;
  logic [CNT_W-1:0] cnt;
  logic             wrap, ovf_hit, ovf_flag;
  logic [N_CH-1:0]  sel, cap_en;

  assign mode = tmr_mode_e'(mode_i);

  cc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  assign ovf_hit = wrap && (mode == MODE_FREE || mode == MODE_PWM);

  cc_opt_reg u_opt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .ovf_hit_i (ovf_hit),
    .we_i      (opt_we_i),
    .wdata_i   (opt_wdata_i),
    .sel_o     (sel),
    .ovf_o     (ovf_flag),
    .irq_o     (ovf_irq_o),
    .rdata_o   (opt_rdata_o)
  );

  // select bits only count in free-running mode
  assign cap_en = (mode == MODE_FREE) ? sel : '0;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    cc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .cap_en_i (cap_en[c]),
      .trig_i   (trig_i[c]),
      .cnt_i    (cnt),
      .we_i     (ch_we_i && (ch_idx_i == IDX_W'(c))),
      .wdata_i  (ch_wdata_i),
      .val_o    (ch_val_o[c*CNT_W +: CNT_W]),
      .match_o  (match_o[c])
    );
  end

  assign cnt_o = cnt;

  p_irq_only_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_FREE && mode != MODE_PWM) |=> !ovf_irq_o);
  p_irq_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag) |-> ovf_irq_o);
endmodule

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
  localparam int W  = 8;
  localparam int NC = 4;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [NC-1:0] trig = '0;
  logic opt_we = 1'b0;
  logic [7:0] opt_wdata = '0;
  logic [7:0] opt_rdata;
  logic ch_we = 1'b0;
  logic [1:0] ch_idx = '0;
  logic [W-1:0] ch_wdata = '0;
  logic [W-1:0] cnt;
  logic [NC*W-1:0] ch_val;
  logic [NC-1:0] match;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cc_timer #(.CNT_W(W)) u_cc_timer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .trig_i(trig),
    .opt_we_i(opt_we), .opt_wdata_i(opt_wdata), .opt_rdata_o(opt_rdata),
    .ch_we_i(ch_we), .ch_idx_i(ch_idx), .ch_wdata_i(ch_wdata),
    .cnt_o(cnt), .ch_val_o(ch_val), .match_o(match), .ovf_irq_o(irq)
  );

  // behavioural reference
  logic [W-1:0] m_cnt;
  logic [3:0]   m_sel;
  logic         m_ovf, m_irq;
  logic [W-1:0] m_ch [NC];
  logic [NC-1:0] m_match, m_trig_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_sel = '0; m_ovf = 0; m_irq = 0; m_match = '0; m_trig_q = '0;
      for (int c = 0; c < NC; c++) m_ch[c] = '0;
    end else begin
      logic hit;
      logic [3:0] eff;
      hit = en && (m_cnt == MAXV) && (mode < 2);
      eff = (mode == 0) ? m_sel : 4'h0;
      for (int c = 0; c < NC; c++) begin
        m_match[c] = en && !eff[c] && (m_cnt == m_ch[c]);
        if (en && eff[c] && trig[c] && !m_trig_q[c]) m_ch[c] = m_cnt;
        else if (ch_we && ch_idx == c) m_ch[c] = ch_wdata;
      end
      m_trig_q = trig;
      if (opt_we && (!en || opt_wdata[7:4] == m_sel)) m_sel = opt_wdata[7:4];
      if (!en) m_ovf = 0;
      else if (hit) m_ovf = 1;
      else if (opt_we && !opt_wdata[0]) m_ovf = 0;
      m_irq = hit;
      m_cnt = en ? m_cnt + 1'b1 : '0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 count", 32'(cnt), 32'(m_cnt));
      chk("R3 R4 R5 R6 flag", 32'(opt_rdata[0]), 32'(m_ovf));
      chk("R7 select", 32'(opt_rdata[7:4]), 32'(m_sel));
      chk("R9 reserved", 32'(opt_rdata[3:1]), 32'd0);
      chk("R3 irq", 32'(irq), 32'(m_irq));
      chk("R11 R8 match", 32'(match), 32'(m_match));
      for (int c = 0; c < NC; c++)
        chk("R10 R8 channel", 32'(ch_val[c*W +: W]), 32'(m_ch[c]));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic opt_wr(logic [7:0] d);
    @(negedge clk); opt_we = 1; opt_wdata = d;
    @(negedge clk); opt_we = 0;
  endtask

  task automatic ch_wr(int i, logic [W-1:0] d);
    @(negedge clk); ch_we = 1; ch_idx = 2'(i); ch_wdata = d;
    @(negedge clk); ch_we = 0;
  endtask

  task automatic wait_cnt(logic [W-1:0] v);
    @(negedge clk);
    while (m_cnt != v) @(negedge clk);
  endtask

  task automatic pulse(int c);
    @(negedge clk); trig[c] = 1;
    step(3); trig[c] = 0;
  endtask

  initial begin
    step(3);
    chk("R1 reset opt", 32'(opt_rdata), 32'd0);
    chk("R1 reset cnt", 32'(cnt), 32'd0);
    chk("R1 reset pulses", 32'({match, irq}), 32'd0);
    chk("R1 reset ch", 32'(ch_val), 32'd0);
    rst_n = 1;
    ch_wr(0, 8'd5); ch_wr(1, 8'h20); ch_wr(2, 8'h80); ch_wr(3, MAXV);
    // free-run compare, one wrap
    @(negedge clk); en = 1; mode = 0;
    step(300);
    opt_wr(8'h01);           // R5: writing 1 does not set
    step(5);
    opt_wr(8'h00);           // R5: clear
    step(5);
    opt_wr(8'hA0);           // R7: different value while enabled, ignored
    step(3);
    opt_wr(8'h00);           // R7: same value accepted
    ch_wr(2, 8'h40);         // R11: change compare while running
    // capture setup
    @(negedge clk); en = 0;
    step(2);
    opt_wr(8'hA0);
    @(negedge clk); en = 1;
    step(20); pulse(1);
    step(30); pulse(3);
    step(10); pulse(0);      // compare channel: trigger ignored
    wait_cnt(8'h60);
    @(negedge clk); trig[1] = 1; ch_we = 1; ch_idx = 1; ch_wdata = 8'h11; // R10 priority
    @(negedge clk); ch_we = 0; trig[1] = 0;
    step(250);
    // R8/R3: other mode, select ignored, no flag on wrap
    opt_wr(8'h00);
    @(negedge clk); mode = 2;
    step(20); pulse(1);
    step(300);
    // pulse-width mode, clear collides with wrap (R5)
    @(negedge clk); mode = 1;
    wait_cnt(MAXV - 1'b1);
    @(negedge clk); opt_we = 1; opt_wdata = 8'hA0;
    @(negedge clk); opt_we = 0;
    step(40);                // R4 persists
    @(negedge clk); en = 0;  // R6
    step(5);
    @(negedge clk); en = 1; mode = 3;
    step(270);
    @(negedge clk); en = 0;
    step(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule